// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that sits behind a small 16-bit register bus and counts a tick that is supplied to it already prescaled. A down-counter starts from a programmable initial value. Each tick, while the timer is not halted, lowers the count by one. When a tick arrives with the count already at zero, the counter expires and reloads itself from the initial value.

Expiry works in two stages. The first expiry only raises a timeout flag. It can also send a one-cycle interrupt pulse toward system-management firmware. Software is expected to service the timer in the meantime, either by rewriting the reload register or by clearing the flag. If the counter expires again while the flag is still set, the block raises a second-timeout flag and asks for a system reset. That request is withheld when a no-reboot override bit is set.

The status flags are cleared by writing 1 to them. The current count can be read back at any time. The tick prescaler, the bus bridge and the reset controller lie outside this block.

Top module: `wdt_two_stage`

## Requirements
- R1: Writing the initial-value register at byte offset 0x12 stores bits [9:0]. Its readback returns that field with bits [15:10] reading 0, and writes to bits [15:10] have no effect. An unmapped offset reads 0, and writes to it change nothing.
- R2: A written initial value of 0, 1, 2 or 3 is stored and read back as 4, so no countdown ever starts below 4.
- R3: Any write to offset 0x00 loads the counter with the stored initial value at the next clock edge, whatever data is written. A read of offset 0x00 returns the current count in bits [9:0].
- R4: While not halted, every cycle with the tick input high lowers the count by one. A tick that arrives with the count at zero is an expiry, and the counter reloads from the initial value. A reload write in the same cycle takes precedence over the tick.
- R5: Control register offset 0x08 holds a halt bit at bit 11 and a no-reboot bit at bit 0, and reads both back as written; its other bits read 0. While halt is 1, ticks do not change the count.
- R6: An expiry with the timeout flag (offset 0x04, bit 3) clear sets that flag. In the following cycle the interrupt output is high for exactly one cycle, but only if the interrupt-enable input was high at the expiry.
- R7: An expiry with the timeout flag already set sets the second-timeout flag (offset 0x06, bit 1). In the following cycle it gives a one-cycle reset request and sets the boot flag (offset 0x06, bit 2). An expiry after the timeout flag has been cleared is a first-stage expiry again.
- R8: With the no-reboot bit set, a second-stage expiry still sets the second-timeout flag, but neither the reset request nor the boot flag is raised.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a set and a clear of the same flag fall in one cycle, the set wins.
- R10: After reset, the initial value and the count are 4, halt is 1, no-reboot is 0, all status flags are 0, and the interrupt and reset request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| tick | input | 1 | Prescaled count enable, one cycle per tick |
| smi_en | input | 1 | Enables the first-stage interrupt pulse |
| irq | output | 1 | One-cycle first-expiry interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check the per-cycle rules on every cycle. These are: the decrement by one on an enabled tick, the frozen count while halted, the load on a reload write, the floor on the initial value, the single-cycle width of the interrupt, and the gating of the reset request by the flags and the override. The bench scenarios cover what needs a history of several expiries. They show the two-stage sequence: first expiry, second expiry, and a first stage again after the flag is cleared. They also show the suppression of the interrupt by its enable, the no-reboot outcome, the clamping of small initial values, and a set winning over a clear in the same cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W = 16;

    typedef logic [7:0] off_t;

    localparam off_t OFF_RELOAD = 8'h00;
    localparam off_t OFF_STS1   = 8'h04;
    localparam off_t OFF_STS2   = 8'h06;
    localparam off_t OFF_CTRL   = 8'h08;
    localparam off_t OFF_INIT   = 8'h12;

    localparam int BIT_TIMEOUT  = 3;
    localparam int BIT_SECOND   = 1;
    localparam int BIT_BOOT     = 2;
    localparam int BIT_HALT     = 11;
    localparam int BIT_NOREBOOT = 0;

    typedef struct packed {
        logic timeout;
        logic second;
        logic boot;
        logic irq;
        logic rst;
    } stage_t;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W    = 10,
    parameter int MIN_INIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(MIN_INIT);

    logic [CNT_W-1:0] cnt_d;
    logic             step;

    always_comb begin
        step   = tick && !halt && !reload_wr;
        expire = step && (cnt_q == '0);
        cnt_d  = cnt_q;
        if (reload_wr) begin
            cnt_d = init_val;
        end else if (expire) begin
            cnt_d = init_val;
        end else if (step) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_RST;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int MIN_INIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  off_t              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_q,
    input  stage_t            stage_q,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  init_q,
    output logic              halt_q,
    output logic              noreboot_q,
    output logic              reload_wr,
    output logic              clr_timeout,
    output logic              clr_second,
    output logic              clr_boot
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_INIT);

    typedef struct packed {
        logic [CNT_W-1:0] init;
        logic             halt;
        logic             noreboot;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [CNT_W-1:0] init_wr;

    always_comb begin
        init_wr     = (bus_wdata[CNT_W-1:0] < FLOOR) ? FLOOR : bus_wdata[CNT_W-1:0];
        cfg_d       = cfg_q;
        reload_wr   = 1'b0;
        clr_timeout = 1'b0;
        clr_second  = 1'b0;
        clr_boot    = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                OFF_RELOAD: reload_wr = 1'b1;
                OFF_INIT:   cfg_d.init = init_wr;
                OFF_CTRL: begin
                    cfg_d.halt     = bus_wdata[BIT_HALT];
                    cfg_d.noreboot = bus_wdata[BIT_NOREBOOT];
                end
                OFF_STS1: clr_timeout = bus_wdata[BIT_TIMEOUT];
                OFF_STS2: begin
                    clr_second = bus_wdata[BIT_SECOND];
                    clr_boot   = bus_wdata[BIT_BOOT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_RELOAD: bus_rdata[CNT_W-1:0] = cnt_q;
            OFF_INIT:   bus_rdata[CNT_W-1:0] = cfg_q.init;
            OFF_CTRL: begin
                bus_rdata[BIT_HALT]     = cfg_q.halt;
                bus_rdata[BIT_NOREBOOT] = cfg_q.noreboot;
            end
            OFF_STS1: bus_rdata[BIT_TIMEOUT] = stage_q.timeout;
            OFF_STS2: begin
                bus_rdata[BIT_SECOND] = stage_q.second;
                bus_rdata[BIT_BOOT]   = stage_q.boot;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.init     <= FLOOR;
            cfg_q.halt     <= 1'b1;
            cfg_q.noreboot <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign init_q     = cfg_q.init;
    assign halt_q     = cfg_q.halt;
    assign noreboot_q = cfg_q.noreboot;
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage
    import wdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   expire,
    input  logic   smi_en,
    input  logic   noreboot,
    input  logic   clr_timeout,
    input  logic   clr_second,
    input  logic   clr_boot,
    output stage_t stage_q
);
    stage_t stage_d;

    always_comb begin
        stage_d     = stage_q;
        stage_d.irq = 1'b0;
        stage_d.rst = 1'b0;
        if (clr_timeout) stage_d.timeout = 1'b0;
        if (clr_second)  stage_d.second  = 1'b0;
        if (clr_boot)    stage_d.boot    = 1'b0;
        if (expire) begin
            if (stage_q.timeout) begin
                stage_d.timeout = 1'b1;
                stage_d.second  = 1'b1;
                if (!noreboot) begin
                    stage_d.rst  = 1'b1;
                    stage_d.boot = 1'b1;
                end
            end else begin
                stage_d.timeout = 1'b1;
                stage_d.irq     = smi_en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int MIN_INIT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        tick,
    input  logic        smi_en,
    output logic        irq,
    output logic        rst_req
);
    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] cnt_q;
    logic             halt_q;
    logic             noreboot_q;
    logic             reload_wr;
    logic             clr_timeout;
    logic             clr_second;
    logic             clr_boot;
    logic             expire;
    stage_t           stage_q;

    wdt_regs #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt_q      (cnt_q),
        .stage_q    (stage_q),
        .bus_rdata  (bus_rdata),
        .init_q     (init_q),
        .halt_q     (halt_q),
        .noreboot_q (noreboot_q),
        .reload_wr  (reload_wr),
        .clr_timeout(clr_timeout),
        .clr_second (clr_second),
        .clr_boot   (clr_boot)
    );

    wdt_counter #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .halt     (halt_q),
        .reload_wr(reload_wr),
        .init_val (init_q),
        .cnt_q    (cnt_q),
        .expire   (expire)
    );

    wdt_stage stage_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .smi_en     (smi_en),
        .noreboot   (noreboot_q),
        .clr_timeout(clr_timeout),
        .clr_second (clr_second),
        .clr_boot   (clr_boot),
        .stage_q    (stage_q)
    );

    assign irq     = stage_q.irq;
    assign rst_req = stage_q.rst;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
    parameter int CNT_W    = 10,
    parameter int MIN_INIT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             halt_q,
    input logic             noreboot_q,
    input logic             reload_wr,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] init_q,
    input logic             irq,
    input logic             rst_req,
    input logic             timeout_flag,
    input logic             second_flag,
    input logic             boot_flag
);
    AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        init_q >= CNT_W'(MIN_INIT)); // R2

    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> (cnt_q == $past(init_q))); // R3

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !halt_q && !reload_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !reload_wr) |=> $stable(cnt_q)); // R5

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6

    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> timeout_flag); // R6

    AST_RST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (second_flag && boot_flag && timeout_flag)); // R7

    AST_RST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(noreboot_q)); // R8
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .halt_q      (halt_q),
    .noreboot_q  (noreboot_q),
    .reload_wr   (reload_wr),
    .cnt_q       (cnt_q),
    .init_q      (init_q),
    .irq         (irq),
    .rst_req     (rst_req),
    .timeout_flag(stage_q.timeout),
    .second_flag (stage_q.second),
    .boot_flag   (stage_q.boot)
);

// File: tb/wdt_two_stage_tb_top.sv
module wdt_two_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick = 1'b0;
    logic        smi_en = 1'b0;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;
    int rst_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wdt_two_stage dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .tick     (tick),
        .smi_en   (smi_en),
        .irq      (irq),
        .rst_req  (rst_req)
    );

    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (rst_req) rst_cnt++;
    end

    typedef struct packed {
        logic [7:0]  a;
        logic [15:0] d;
        logic [15:0] e;
        logic [7:0]  req;
    } vec_t;

    // R1 / R2 / R5: write then read back
    localparam vec_t VEC [12] = '{
        '{8'h12, 16'h0005, 16'h0005, 8'd1},
        '{8'h12, 16'h0002, 16'h0004, 8'd2},
        '{8'h12, 16'h0000, 16'h0004, 8'd2},
        '{8'h12, 16'h0003, 16'h0004, 8'd2},
        '{8'h12, 16'h03FF, 16'h03FF, 8'd1},
        '{8'h12, 16'hFC10, 16'h0010, 8'd1},
        '{8'h08, 16'h0801, 16'h0801, 8'd5},
        '{8'h08, 16'hF7FE, 16'h0000, 8'd5},
        '{8'h08, 16'hFFFF, 16'h0801, 8'd5},
        '{8'h08, 16'h0800, 16'h0800, 8'd5},
        '{8'h12, 16'h0005, 16'h0005, 8'd1},
        '{8'h0C, 16'h1234, 16'h0000, 8'd1}
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(8'h12, v); chk("R10 init", v, 16'h0004);
        rd(8'h00, v); chk("R10 count", v, 16'h0004);
        rd(8'h08, v); chk("R10 ctrl", v, 16'h0800);
        rd(8'h04, v); chk("R10 sts1", v, 16'h0000);
        rd(8'h06, v); chk("R10 sts2", v, 16'h0000);
        chk("R10 irq", {15'd0, irq}, 16'h0000);
        chk("R10 rst_req", {15'd0, rst_req}, 16'h0000);

        // R5 halted counter ignores ticks
        ticks(3);
        rd(8'h00, v); chk("R5 halted count", v, 16'h0004);

        for (int i = 0; i < 12; i++) begin
            wr(VEC[i].a, VEC[i].d);
            rd(VEC[i].a, v);
            checks++;
            if (v !== VEC[i].e) begin
                fails++;
                $display("FAIL R%0d vector %0d: got 0x%04h expected 0x%04h", VEC[i].req, i, v, VEC[i].e);
            end
        end

        // R3 reload loads initial value 5
        wr(8'h00, 16'hABCD);
        rd(8'h00, v); chk("R3 reload", v, 16'h0005);
        wr(8'h08, 16'h0000);
        smi_en = 1'b1;
        ticks(2);
        rd(8'h00, v); chk("R4 decrement", v, 16'h0003);
        ticks(3);
        rd(8'h00, v); chk("R4 at zero", v, 16'h0000);
        ticks(1);
        rd(8'h00, v); chk("R4 reload on expiry", v, 16'h0005);
        chk("R6 irq pulse", {15'd0, irq}, 16'h0001);
        rd(8'h04, v); chk("R6 timeout flag", v, 16'h0008);
        rd(8'h06, v); chk("R6 no second stage", v, 16'h0000);
        @(negedge clk);
        chk("R6 irq one cycle", {15'd0, irq}, 16'h0000);

        // R9 writing zero leaves the flag
        wr(8'h04, 16'h0000);
        rd(8'h04, v); chk("R9 write zero", v, 16'h0008);

        // R7 second expiry with flag still set
        ticks(6);
        chk("R7 rst_req", {15'd0, rst_req}, 16'h0001);
        rd(8'h06, v); chk("R7 sts2", v, 16'h0006);
        @(negedge clk);
        chk("R7 rst one cycle", rst_cnt[15:0], 16'd1);
        chk("R7 irq count", irq_cnt[15:0], 16'd1);

        // R9 write-one clears
        wr(8'h06, 16'h0006);
        rd(8'h06, v); chk("R9 clear sts2", v, 16'h0000);
        wr(8'h04, 16'h0008);
        rd(8'h04, v); chk("R9 clear sts1", v, 16'h0000);

        // R6 interrupt gated by smi_en
        smi_en = 1'b0;
        ticks(6);
        rd(8'h04, v); chk("R6 flag without irq", v, 16'h0008);
        chk("R6 irq gated", irq_cnt[15:0], 16'd1);
        wr(8'h04, 16'h0008);
        ticks(6);
        rd(8'h06, v); chk("R7 cleared flag restarts stage", v, 16'h0000);
        chk("R7 no reset after clear", rst_cnt[15:0], 16'd1);

        // R8 no-reboot override
        wr(8'h08, 16'h0001);
        ticks(6);
        rd(8'h06, v); chk("R8 second flag only", v, 16'h0002);
        @(negedge clk);
        chk("R8 reset suppressed", rst_cnt[15:0], 16'd1);

        // R3 reload mid-countdown
        wr(8'h00, 16'h0000);
        ticks(2);
        rd(8'h00, v); chk("R3 count before reload", v, 16'h0003);
        wr(8'h00, 16'hFFFF);
        rd(8'h00, v); chk("R3 reload mid count", v, 16'h0005);

        // R9 set wins over same-cycle clear
        wr(8'h04, 16'h0008);
        wr(8'h06, 16'h0006);
        ticks(5);
        @(negedge clk);
        tick = 1'b1; bus_addr = 8'h04; bus_wdata = 16'h0008; bus_wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rd(8'h04, v); chk("R9 set wins", v, 16'h0008);

        // R4 reload write beats tick
        @(negedge clk);
        tick = 1'b1; bus_addr = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rd(8'h00, v); chk("R4 reload over tick", v, 16'h0005);

        done = 1;
        finish_run();
    end
endmodule